// File: doc/BRIEF.md
# Tag-Table Line Cache with Silent-Write Filtering

This block is a set-associative cache for a tag table held in external memory. The table stores one tag bit for each 32-byte (256-bit) data word. A client sends single-bit tag reads and tag writes, each addressed by a data byte address. The block turns the address into a table line address and a bit position within that line, and it answers from its local lines whenever the line is present.

On a miss, the block fetches the whole 1024-bit table line through a line-wide memory port. If the chosen victim line is dirty, the block first writes that line back through the same port. While a miss is being handled, the request interface stays stalled. A write that stores the value the bit already holds does not mark its line dirty. As a result, writeback traffic depends on how the tag values change, not on how many writes arrive.

Top module: `tagc_cache`

## Requirements
- R1: The tag index is the byte address shifted right by 5. The bit position is the low 10 bits of the tag index. The line address is the tag index shifted right by 10, and its low log2(SETS) bits select the set. Every memory-port transaction carries this line address.
- R2: A read accepted at a clock edge raises rsp_valid for exactly the following cycle, with rsp_rdata equal to the current tag bit. An accepted write raises no response.
- R3: A request whose line is resident is accepted without any memory-port transaction.
- R4: On a miss, req_ready stays low until the fetched line is installed. Exactly one line read per miss is issued, and the request is accepted only after the fill.
- R5: A write whose value equals the stored bit leaves the line clean. If such a line is later evicted, no writeback is issued for it.
- R6: A write that changes the bit marks the line dirty. When a dirty line is evicted, the block issues one write transaction carrying the full updated line, and it issues that write before the fill read for the new line.
- R7: Within a set, an invalid way is always filled before any valid way is evicted. After reset, four distinct lines mapping to one set all become resident together, with no writeback.
- R8: When a set is full, the victim is the way given by a per-set pointer. Each fill moves that pointer to the way after the one just filled, wrapping modulo the number of ways.
- R9: A memory request held without mem_req_ready keeps its valid, direction and address unchanged until it is accepted.
- R10: After reset, no line is valid. rsp_valid and mem_req_valid are low, and the first access to any line misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Tag request present |
| req_ready | output | 1 | Request accepted this cycle (line resident) |
| req_write | input | 1 | 1 = write tag, 0 = read tag |
| req_addr | input | ADDR_W | Data byte address |
| req_wdata | input | 1 | Tag value to write |
| rsp_valid | output | 1 | Read result valid |
| rsp_rdata | output | 1 | Read tag value |
| mem_req_valid | output | 1 | Memory line transaction present |
| mem_req_ready | input | 1 | Memory accepts the transaction |
| mem_req_write | output | 1 | 1 = line writeback, 0 = line fetch |
| mem_req_addr | output | ADDR_W-15 | Table line address |
| mem_req_wdata | output | LINE_TAGS | Line contents for a writeback |
| mem_rsp_valid | input | 1 | Fetched line returned |
| mem_rsp_rdata | input | LINE_TAGS | Fetched line contents |

## Verification
Directed sequences fill a single set with four lines to confirm that invalid ways are used first and that repeat accesses cost no traffic. A write that repeats the stored value and a write that flips a bit are then placed on two lines, and both lines are evicted. This separates a clean eviction from a writeback and checks that the flipped bit comes back after the line is refetched. Random mixed reads and writes over six lines per set, with random memory stall and latency, are checked against a reference model of table contents and victim order. This exposes errors in address slicing, dirty tracking, the ordering of writeback before fill, and stalled-handshake holding.

// File: rtl/tagc_pkg.sv
// Shared types for the tag-table line cache.
package tagc_pkg;
    // Miss-handling sequence of the cache controller.
    typedef enum logic [1:0] {
        ST_LOOK      = 2'd0,
        ST_WB        = 2'd1,
        ST_FILL_REQ  = 2'd2,
        ST_FILL_WAIT = 2'd3
    } tagc_state_e;
endpackage

// File: rtl/tagc_addr_split.sv
// Splits a data byte address into table line address, set, line tag and
// bit position. Assumes WORD_BYTES and LINE_TAGS are powers of two.
module tagc_addr_split #(
    parameter int ADDR_W  = 32,
    parameter int OFF_W   = 5,
    parameter int BIT_W   = 10,
    parameter int SET_W   = 2,
    parameter int LADDR_W = 17,
    parameter int TAG_W   = 15
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [BIT_W-1:0]   bit_off,
    output logic [SET_W-1:0]   set_idx,
    output logic [TAG_W-1:0]   line_tag,
    output logic [LADDR_W-1:0] line_addr
);
    // Word index = byte address / word size; it splits into line and bit.
    assign {line_addr, bit_off} = addr[ADDR_W-1:OFF_W];
    assign set_idx  = line_addr[SET_W-1:0];
    assign line_tag = line_addr[LADDR_W-1:SET_W];
endmodule

// File: rtl/tagc_victim.sv
// Chooses the way to replace in a set: the lowest invalid way if any,
// otherwise the round-robin pointer. Assumes WAYS is a power of two.
module tagc_victim #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]  valid_in,
    input  logic [WAY_W-1:0] ptr_in,
    output logic [WAY_W-1:0] way_out
);
    // Priority scan for a free way, falling back to the pointer.
    always_comb begin
        logic found;
        found   = 1'b0;
        way_out = ptr_in;
        for (int w = 0; w < WAYS; w++) begin
            if (!valid_in[w] && !found) begin
                way_out = WAY_W'(w);
                found   = 1'b1;
            end
        end
    end

    // A free way must be preferred over any valid one.
    always_comb begin
        if (!(&valid_in)) begin
            assert_invalid_first_R7: assert (!valid_in[way_out]);
        end
    end
endmodule

// File: rtl/tagc_store.sv
// Line storage: valid, dirty, line tag and 1024-bit data per way, plus a
// round-robin pointer per set. A lookup port drives hit detection, the
// single-bit read and the single-bit write. The dirty flag is raised only
// when a write changes the stored bit. A fill installs a clean line.
module tagc_store #(
    parameter int SETS      = 4,
    parameter int WAYS      = 4,
    parameter int LINE_TAGS = 1024,
    parameter int SET_W     = 2,
    parameter int WAY_W     = 2,
    parameter int BIT_W     = 10,
    parameter int TAG_W     = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SET_W-1:0]     lk_set,
    input  logic [TAG_W-1:0]     lk_tag,
    input  logic [BIT_W-1:0]     lk_off,
    output logic                 lk_hit,
    output logic [WAY_W-1:0]     lk_way,
    output logic                 lk_bit,
    output logic [WAYS-1:0]      set_valid,
    output logic [WAYS-1:0]      set_dirty,
    output logic [WAY_W-1:0]     set_ptr,
    input  logic                 wr_en,
    input  logic                 wr_val,
    input  logic                 fill_en,
    input  logic [SET_W-1:0]     fill_set,
    input  logic [WAY_W-1:0]     fill_way,
    input  logic [TAG_W-1:0]     fill_tag,
    input  logic [LINE_TAGS-1:0] fill_line,
    input  logic [SET_W-1:0]     vic_set,
    input  logic [WAY_W-1:0]     vic_way,
    output logic [TAG_W-1:0]     vic_tag,
    output logic [LINE_TAGS-1:0] vic_line
);
    localparam int IDX_W  = SET_W + WAY_W;
    localparam int NLINES = 1 << IDX_W;

    logic [NLINES-1:0]    valid_q;
    logic [NLINES-1:0]    dirty_q;
    logic [TAG_W-1:0]     tag_q  [NLINES];
    logic [LINE_TAGS-1:0] data_q [NLINES];
    logic [WAY_W-1:0]     ptr_q  [SETS];
    logic [WAYS-1:0]      hit_vec;

    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] fill_idx;
    logic [IDX_W-1:0] vic_idx;

    assign fill_idx = {fill_set, fill_way};
    assign vic_idx  = {vic_set, vic_way};

    // Per-way tag compare and set-wide state for the looked-up set.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        localparam logic [WAY_W-1:0] WID = WAY_W'(w);
        assign hit_vec[w]   = valid_q[{lk_set, WID}] && (tag_q[{lk_set, WID}] == lk_tag);
        assign set_valid[w] = valid_q[{lk_set, WID}];
        assign set_dirty[w] = dirty_q[{lk_set, WID}];
    end

    // Encode the hitting way (at most one way matches).
    always_comb begin
        lk_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) lk_way = WAY_W'(w);
        end
    end

    assign lk_hit   = |hit_vec;
    assign wr_idx   = {lk_set, lk_way};
    assign lk_bit   = data_q[wr_idx][lk_off];
    assign set_ptr  = ptr_q[lk_set];
    assign vic_tag  = tag_q[vic_idx];
    assign vic_line = data_q[vic_idx];

    // Line state: valid, dirty and the replacement pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
        end else begin
            if (wr_en && (lk_bit != wr_val)) dirty_q[wr_idx] <= 1'b1;
            if (fill_en) begin
                valid_q[fill_idx] <= 1'b1;
                dirty_q[fill_idx] <= 1'b0;
                ptr_q[fill_set]   <= fill_way + 1'b1;
            end
        end
    end

    // Line tag and contents; meaningful only where valid is set.
    always_ff @(posedge clk) begin
        if (wr_en) data_q[wr_idx][lk_off] <= wr_val;
        if (fill_en) begin
            data_q[fill_idx] <= fill_line;
            tag_q[fill_idx]  <= fill_tag;
        end
    end

    assert_silent_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_val == lk_bit)) |=> $stable(dirty_q));

    assert_change_dirty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_val != lk_bit)) |=> dirty_q[$past(wr_idx)]);

    assert_fill_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (valid_q[$past(fill_idx)] && !dirty_q[$past(fill_idx)]));
endmodule

// File: rtl/tagc_cache.sv
// Tag-table line cache. Single-bit tag requests hit locally. A miss stalls
// req_ready, writes back a dirty victim, fetches the line and installs it.
// The held request is then accepted as a hit. Assumes the requester holds
// a request stable until req_ready, and that SETS and WAYS are powers of
// two, each at least 2.
module tagc_cache #(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 32,
    parameter int LINE_TAGS  = 1024,
    parameter int SETS       = 4,
    parameter int WAYS       = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               req_valid,
    output logic                               req_ready,
    input  logic                               req_write,
    input  logic [ADDR_W-1:0]                  req_addr,
    input  logic                               req_wdata,
    output logic                               rsp_valid,
    output logic                               rsp_rdata,
    output logic                               mem_req_valid,
    input  logic                               mem_req_ready,
    output logic                               mem_req_write,
    output logic [ADDR_W-$clog2(WORD_BYTES)-$clog2(LINE_TAGS)-1:0] mem_req_addr,
    output logic [LINE_TAGS-1:0]               mem_req_wdata,
    input  logic                               mem_rsp_valid,
    input  logic [LINE_TAGS-1:0]               mem_rsp_rdata
);
    import tagc_pkg::*;

    localparam int OFF_W   = $clog2(WORD_BYTES);
    localparam int BIT_W   = $clog2(LINE_TAGS);
    localparam int SET_W   = $clog2(SETS);
    localparam int WAY_W   = $clog2(WAYS);
    localparam int LADDR_W = ADDR_W - OFF_W - BIT_W;
    localparam int TAG_W   = LADDR_W - SET_W;

    tagc_state_e       state_q;
    logic [SET_W-1:0]  miss_set_q;
    logic [TAG_W-1:0]  miss_tag_q;
    logic [WAY_W-1:0]  miss_way_q;
    logic              rsp_valid_q;
    logic              rsp_rdata_q;

    logic [BIT_W-1:0]   a_off;
    logic [SET_W-1:0]   a_set;
    logic [TAG_W-1:0]   a_tag;
    logic [LADDR_W-1:0] a_line;

    logic              lk_hit;
    logic [WAY_W-1:0]  lk_way;
    logic              lk_bit;
    logic [WAYS-1:0]   set_valid;
    logic [WAYS-1:0]   set_dirty;
    logic [WAY_W-1:0]  set_ptr;
    logic [WAY_W-1:0]  vic_way;
    logic [TAG_W-1:0]  vic_tag;
    logic              accept;
    logic              fill_en;

    tagc_addr_split #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .BIT_W(BIT_W),
        .SET_W(SET_W), .LADDR_W(LADDR_W), .TAG_W(TAG_W)
    ) u_split (
        .addr(req_addr), .bit_off(a_off), .set_idx(a_set),
        .line_tag(a_tag), .line_addr(a_line)
    );

    tagc_store #(
        .SETS(SETS), .WAYS(WAYS), .LINE_TAGS(LINE_TAGS), .SET_W(SET_W),
        .WAY_W(WAY_W), .BIT_W(BIT_W), .TAG_W(TAG_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .lk_set(a_set), .lk_tag(a_tag), .lk_off(a_off),
        .lk_hit(lk_hit), .lk_way(lk_way), .lk_bit(lk_bit),
        .set_valid(set_valid), .set_dirty(set_dirty), .set_ptr(set_ptr),
        .wr_en(accept && req_write), .wr_val(req_wdata),
        .fill_en(fill_en), .fill_set(miss_set_q), .fill_way(miss_way_q),
        .fill_tag(miss_tag_q), .fill_line(mem_rsp_rdata),
        .vic_set(miss_set_q), .vic_way(miss_way_q),
        .vic_tag(vic_tag), .vic_line(mem_req_wdata)
    );

    tagc_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
        .valid_in(set_valid), .ptr_in(set_ptr), .way_out(vic_way)
    );

    assign req_ready = (state_q == ST_LOOK) && req_valid && lk_hit;
    assign accept    = req_ready;
    assign fill_en   = (state_q == ST_FILL_WAIT) && mem_rsp_valid;

    // Memory port driven purely from controller state and latched miss info.
    assign mem_req_valid = (state_q == ST_WB) || (state_q == ST_FILL_REQ);
    assign mem_req_write = (state_q == ST_WB);
    assign mem_req_addr  = (state_q == ST_WB) ? {vic_tag, miss_set_q}
                                              : {miss_tag_q, miss_set_q};
    assign rsp_valid = rsp_valid_q;
    assign rsp_rdata = rsp_rdata_q;

    // Miss sequencing: optional writeback, then fetch, then install.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_LOOK;
            miss_set_q <= '0;
            miss_tag_q <= '0;
            miss_way_q <= '0;
        end else begin
            case (state_q)
                ST_LOOK: begin
                    if (req_valid && !lk_hit) begin
                        miss_set_q <= a_set;
                        miss_tag_q <= a_tag;
                        miss_way_q <= vic_way;
                        state_q    <= (set_valid[vic_way] && set_dirty[vic_way])
                                      ? ST_WB : ST_FILL_REQ;
                    end
                end
                ST_WB:        if (mem_req_ready) state_q <= ST_FILL_REQ;
                ST_FILL_REQ:  if (mem_req_ready) state_q <= ST_FILL_WAIT;
                ST_FILL_WAIT: if (mem_rsp_valid) state_q <= ST_LOOK;
                default:      state_q <= ST_LOOK;
            endcase
        end
    end

    // Read response one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_rdata_q <= 1'b0;
        end else begin
            rsp_valid_q <= accept && !req_write;
            rsp_rdata_q <= lk_bit;
        end
    end

    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> rsp_valid);

    assert_rsp_only_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready && !req_write));

    assert_hit_no_traffic_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid);

    assert_hold_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_write) && $stable(mem_req_addr)));

    assert_wb_then_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready && mem_req_write) |=>
            (mem_req_valid && !mem_req_write &&
             mem_req_addr[SET_W-1:0] == $past(mem_req_addr[SET_W-1:0])));
endmodule

// File: tb/tagc_cache_bench.sv
// Bench for tagc_cache: directed set-filling and silent-write cases followed
// by seeded random traffic, checked against a reference model.
module tagc_cache_bench;
    localparam int PERIOD    = 10;
    localparam int ADDR_W    = 32;
    localparam int LINE_TAGS = 1024;
    localparam int SETS      = 4;
    localparam int WAYS      = 4;
    localparam int LADDR_W   = ADDR_W - 5 - 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_wdata = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic req_ready, rsp_valid, rsp_rdata;
    logic mem_req_valid, mem_req_write;
    logic mem_req_ready = 1'b0;
    logic [LADDR_W-1:0] mem_req_addr;
    logic [LINE_TAGS-1:0] mem_req_wdata;
    logic mem_rsp_valid = 1'b0;
    logic [LINE_TAGS-1:0] mem_rsp_rdata = '0;

    int n_chk = 0, n_fail = 0;
    int act_rd = 0, act_wr = 0, last_rd_la = -1, last_wr_la = -1;
    logic [LINE_TAGS-1:0] gold [int];
    logic [LINE_TAGS-1:0] mem  [int];
    bit m_valid [SETS][WAYS];
    bit m_dirty [SETS][WAYS];
    int m_la    [SETS][WAYS];
    int m_ptr   [SETS];

    always #(PERIOD/2) clk = ~clk;

    tagc_cache #(.ADDR_W(ADDR_W), .LINE_TAGS(LINE_TAGS), .SETS(SETS), .WAYS(WAYS)) u_tagc_cache (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata)
    );

    function automatic logic [LINE_TAGS-1:0] init_line(input int la);
        logic [LINE_TAGS-1:0] v;
        for (int i = 0; i < LINE_TAGS / 32; i++)
            v[i*32 +: 32] = 32'(la) * 32'h9E3779B1 + 32'(i) * 32'h7F4A7C15;
        return v;
    endfunction

    function automatic logic [LINE_TAGS-1:0] gold_line(input int la);
        if (gold.exists(la)) return gold[la];
        return init_line(la);
    endfunction

    function automatic logic [ADDR_W-1:0] mk_addr(input int la, input int bt);
        return (ADDR_W'(la) << 15) | (ADDR_W'(bt) << 5);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Memory responder: random acceptance and 1..3 cycle fill latency.
    initial begin
        int cnt = 0;
        logic [LINE_TAGS-1:0] pend;
        bit held = 1'b0;
        int held_la = 0;
        bit held_wr = 1'b0;
        pend = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_rdata = pend;
                end
            end
            if (held) begin
                chk(mem_req_valid && mem_req_write == held_wr && int'(mem_req_addr) == held_la,
                    "R9", "stalled request changed (addr)", int'(mem_req_addr), held_la);
            end
            mem_req_ready = ($urandom % 3) != 0;
            held = mem_req_valid && !mem_req_ready;
            held_la = int'(mem_req_addr);
            held_wr = mem_req_write;
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_write) begin
                    act_wr++;
                    last_wr_la = int'(mem_req_addr);
                    chk(mem_req_wdata == gold_line(last_wr_la), "R6",
                        "writeback line contents differ, line", last_wr_la, last_wr_la);
                    mem[last_wr_la] = mem_req_wdata;
                end else begin
                    act_rd++;
                    last_rd_la = int'(mem_req_addr);
                    pend = mem.exists(last_rd_la) ? mem[last_rd_la] : init_line(last_rd_la);
                    cnt = 1 + int'($urandom % 3);
                end
            end
        end
    end

    // One tag request, checked against the reference model.
    task automatic do_op(input bit wr, input int la, input int bt, input bit wv,
                         input string req);
        int s, hw, vw, rd0, wr0, exp_rd, exp_wr, vic_la;
        bit exp_bit;
        logic [LINE_TAGS-1:0] g;
        s = la % SETS;
        hw = -1;
        for (int w = 0; w < WAYS; w++) if (m_valid[s][w] && m_la[s][w] == la) hw = w;
        exp_rd = 0; exp_wr = 0; vw = 0; vic_la = -1;
        if (hw < 0) begin
            exp_rd = 1;
            vw = m_ptr[s];
            for (int w = WAYS - 1; w >= 0; w--) if (!m_valid[s][w]) vw = w;
            if (m_valid[s][vw] && m_dirty[s][vw]) begin
                exp_wr = 1;
                vic_la = m_la[s][vw];
            end
        end
        rd0 = act_rd; wr0 = act_wr;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = mk_addr(la, bt); req_wdata = wv;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(act_rd - rd0 == exp_rd, req, "line fetches for request", act_rd - rd0, exp_rd);
        chk(act_wr - wr0 == exp_wr, req, "writebacks for request", act_wr - wr0, exp_wr);
        if (exp_rd == 1) chk(last_rd_la == la, "R1", "fetched line address", last_rd_la, la);
        if (exp_wr == 1) chk(last_wr_la == vic_la, "R6", "written-back line address", last_wr_la, vic_la);
        g = gold_line(la);
        exp_bit = g[bt];
        if (!wr) begin
            chk(rsp_valid == 1'b1, "R2", "rsp_valid after read", int'(rsp_valid), 1);
            chk(rsp_rdata == exp_bit, "R2", "read tag value", int'(rsp_rdata), int'(exp_bit));
        end else begin
            chk(rsp_valid == 1'b0, "R2", "rsp_valid after write", int'(rsp_valid), 0);
        end
        if (hw < 0) begin
            m_valid[s][vw] = 1'b1; m_dirty[s][vw] = 1'b0; m_la[s][vw] = la;
            m_ptr[s] = (vw + 1) % WAYS;
            hw = vw;
        end
        if (wr && exp_bit != wv) begin
            g[bt] = wv;
            gold[la] = g;
            m_dirty[s][hw] = 1'b1;
        end
    endtask

    function automatic bit cur_bit(input int la, input int bt);
        logic [LINE_TAGS-1:0] g;
        g = gold_line(la);
        return g[bt];
    endfunction

    initial begin
        #(PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        for (int s = 0; s < SETS; s++) begin
            m_ptr[s] = 0;
            for (int w = 0; w < WAYS; w++) begin
                m_valid[s][w] = 1'b0; m_dirty[s][w] = 1'b0; m_la[s][w] = -1;
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R10", "rsp_valid after reset", int'(rsp_valid), 0);
        chk(mem_req_valid == 1'b0, "R10", "mem_req_valid after reset", int'(mem_req_valid), 0);
        chk(req_ready == 1'b0, "R10", "req_ready idle after reset", int'(req_ready), 0);

        // R7/R10: four lines of set 1 fill the free ways with no writeback.
        do_op(1'b0, 1, 10, 1'b0, "R10");
        do_op(1'b0, 5, 20, 1'b0, "R7");
        do_op(1'b0, 9, 30, 1'b0, "R7");
        do_op(1'b0, 13, 40, 1'b0, "R7");
        // R3: all four stay resident.
        do_op(1'b0, 1, 11, 1'b0, "R3");
        do_op(1'b0, 5, 21, 1'b0, "R3");
        do_op(1'b0, 9, 31, 1'b0, "R3");
        do_op(1'b0, 13, 41, 1'b0, "R3");
        // R5: rewrite of the stored value; R6: a changing write.
        do_op(1'b1, 1, 3, cur_bit(1, 3), "R5");
        do_op(1'b1, 5, 4, !cur_bit(5, 4), "R6");
        // R5: evicting line 1 (clean) costs no writeback; R6: line 5 is written back.
        do_op(1'b0, 17, 0, 1'b0, "R5");
        do_op(1'b0, 21, 0, 1'b0, "R6");
        // R8: pointer now at way 2, so line 9 is the next victim.
        do_op(1'b0, 13, 5, 1'b0, "R3");
        do_op(1'b0, 25, 5, 1'b0, "R8");
        do_op(1'b0, 13, 6, 1'b0, "R8");
        do_op(1'b0, 17, 6, 1'b0, "R8");
        // R6: the flipped bit survives the round trip through memory.
        do_op(1'b0, 5, 4, 1'b0, "R6");
        // R4: misses and hits mixed at random over six lines per set.
        for (int i = 0; i < 400; i++) begin
            int la, bt;
            la = int'($urandom % 24);
            bt = int'($urandom % 16) * 64 + int'($urandom % 2);
            do_op(1'($urandom % 2), la, bt, 1'($urandom % 2), "R4");
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule